// File: doc/BRIEF.md
# External Interrupt Sense and Vector Controller

This block collects eight active-low external interrupt pins and a parameterised group of active-low internal sources. It turns them into one interrupt request to the processor and a vector number that names the source to service. For each external pin, software chooses between low-level sensing and falling-edge sensing. Edge events are held in a pending latch until software clears them with a write-one. Internal sources are always level sensitive.

Software reaches the block through a plain 32-bit register port with a 3-bit word address. Reads are combinational. Writes take effect at the next rising clock edge. Per-source enable bits decide which pending sources may compete for the vector. Among the enabled pending sources, the lowest source number wins. A vector of zero means nothing is pending.

Top module: `extint_vec_ctl`

## Requirements
- R1: A synchronous active-low reset clears every enable bit, every sense bit and every edge latch. After reset all readable registers return zero and `cpu_irq` is low.
- R2: The sense register sits at word address 0. External pin k uses bit 15-k, counted from the LSB, so pin 0 uses bit 15 and pin 7 uses bit 8. A 1 selects falling-edge sensing and a 0 selects low-level sensing. All other bits read as zero.
- R3: The external enable register is at address 1 and the external pending register at address 2. In both, pin k sits at bit 31-k. The internal enable register is at address 3, with internal source i at bit 31-i. A 1 enables a source.
- R4: In level mode, an external pin reads as pending exactly while its input is low, delayed by a two-flop synchroniser: low at one rising edge, pending after the second. Writing 1 to its pending bit has no effect.
- R5: In edge mode, a high-to-low transition of the synchronised input sets the pin's pending latch. The latch stays set after the input returns high. A rising transition, or a pin held low, sets nothing.
- R6: Writing 1 to a pending bit clears that edge latch, and writing 0 leaves it unchanged. If a new falling edge arrives in the same cycle as the clear, the latch stays set.
- R7: The enable bits gate only the vector and `cpu_irq`. A disabled source still shows in the pending register and wins the vector as soon as it is enabled.
- R8: The vector register is at address 4 and is read-only, with the number in bits [6:0]. The source numbers are 48 for external pin 0, 16+k for external pin k (1 to 7), and INT_BASE+i (default 64) for internal source i. The lowest enabled pending number is reported.
- R9: The vector reads 0 when no enabled source is pending. `cpu_irq` is high exactly while the vector is nonzero.
- R10: An internal source is pending while its input is low. Its input reaches the vector with no register delay.
- R11: Writes to the vector address or to unused addresses change nothing, and unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq_n | input | 8 | External interrupt pins, active low, asynchronous |
| int_irq_n | input | NUM_INT (8) | Internal level interrupt sources, active low, clock-synchronous |
| reg_addr | input | 3 | Register word address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions check several properties on every cycle. An edge latch never drops unless a clear was written the cycle before. A falling edge seen in edge mode is always captured. `cpu_irq` matches the presence of any enabled pending source. The vector only ever holds zero or a legal source number. Reset leaves the enables and sense bits cleared. Only the bench scenarios can show the rest: that the lowest number wins across mixed external and internal patterns, the exact two-edge synchroniser latency, the bit positions of each register, that a set beats a clear in the same cycle, and that writes to read-only or level-mode bits are ignored.

// File: rtl/irq_ctl_pkg.sv
// Package: shared constants for the interrupt sense/vector controller.
// Assumes a 32-bit register port and a 7-bit vector field.
package irq_ctl_pkg;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 3;
    localparam int VEC_W        = 7;
    localparam int EXT_LINES    = 8;
    localparam int EXT0_SRC_NUM = 48;
    localparam int EXT_SRC_BASE = 16;

    localparam logic [ADDR_W-1:0] A_SENSE = 3'd0;
    localparam logic [ADDR_W-1:0] A_EMASK = 3'd1;
    localparam logic [ADDR_W-1:0] A_EPEND = 3'd2;
    localparam logic [ADDR_W-1:0] A_IMASK = 3'd3;
    localparam logic [ADDR_W-1:0] A_VEC   = 3'd4;

    // Source number of external pin k.
    function automatic logic [VEC_W-1:0] ext_src_num(input int k);
        return (k == 0) ? VEC_W'(EXT0_SRC_NUM) : VEC_W'(EXT_SRC_BASE + k);
    endfunction
endpackage

// File: rtl/irq_line_sense.sv
// Module: per-pin sense logic for one active-low external interrupt.
// Synchronises the pin, detects high-to-low transitions and holds them in a
// latch in edge mode; in level mode reports the synchronised low level.
// Assumes irq_n is asynchronous to clk. A set beats a clear in the same cycle.
module irq_line_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    input  logic edge_mode,
    input  logic clr,
    output logic pending
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   latch_q;
    logic                   settled;
    logic                   fall;

    assign settled = sync_q[SYNC_STAGES-1];
    assign fall    = prev_q & ~settled;

    // Synchronise the pin and remember the previous settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], irq_n};
            prev_q <= settled;
        end
    end

    // Edge latch: set on a fall, cleared by a write-one, held at 0 in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= 1'b0;
        else if (!edge_mode) latch_q <= 1'b0;
        else if (fall)       latch_q <= 1'b1;
        else if (clr)        latch_q <= 1'b0;
    end

    // Report the latch in edge mode, the synchronised low level otherwise.
    assign pending = edge_mode ? latch_q : ~settled;

    // R6: an edge latch only drops after a clear write.
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && $past(edge_mode) && $fell(latch_q)) |-> $past(clr));

    // R5: a fall seen in edge mode is always captured.
    p_edge_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && $past(edge_mode) && $past(fall)) |-> latch_q);
endmodule

// File: rtl/irq_vector_sel.sv
// Module: picks the lowest source number among the asserted requests.
// Assumes no valid source number is zero; zero means no request.
module irq_vector_sel #(
    parameter int NUM_SRC = 16,
    parameter int VEC_W   = 7
) (
    input  logic [NUM_SRC-1:0]            req,
    input  logic [NUM_SRC-1:0][VEC_W-1:0] src_num,
    output logic [VEC_W-1:0]              vec
);
    // Scan all requests and keep the smallest number found.
    always_comb begin
        vec = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (req[s] && (vec == '0 || src_num[s] < vec)) vec = src_num[s];
        end
    end
endmodule

// File: rtl/extint_vec_ctl.sv
// Module: top of the interrupt sense/vector controller. Holds the sense and
// enable registers, decodes the register port and drives the vector and the
// processor request. Assumes int_irq_n is synchronous to clk.
module extint_vec_ctl
    import irq_ctl_pkg::*;
#(
    parameter int NUM_INT     = 8,
    parameter int INT_BASE    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         ext_irq_n,
    input  logic [NUM_INT-1:0] int_irq_n,
    input  logic [2:0]         reg_addr,
    input  logic               reg_wr_en,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               cpu_irq
);
    localparam int NUM_SRC = EXT_LINES + NUM_INT;

    logic [EXT_LINES-1:0]            sense_q;
    logic [EXT_LINES-1:0]            emask_q;
    logic [NUM_INT-1:0]              imask_q;
    logic [EXT_LINES-1:0]            ext_pend;
    logic [EXT_LINES-1:0]            ext_clr;
    logic [NUM_SRC-1:0]              req;
    logic [NUM_SRC-1:0][VEC_W-1:0]   src_num;
    logic [VEC_W-1:0]                vec;
    logic                            wr_sense, wr_emask, wr_epend, wr_imask;

    assign wr_sense = reg_wr_en && (reg_addr == A_SENSE);
    assign wr_emask = reg_wr_en && (reg_addr == A_EMASK);
    assign wr_epend = reg_wr_en && (reg_addr == A_EPEND);
    assign wr_imask = reg_wr_en && (reg_addr == A_IMASK);

    // Per external pin: sense/enable bits, clear decode and sense logic.
    for (genvar k = 0; k < EXT_LINES; k++) begin : g_ext
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sense_q[k] <= 1'b0;
                emask_q[k] <= 1'b0;
            end else begin
                if (wr_sense) sense_q[k] <= reg_wdata[15-k];
                if (wr_emask) emask_q[k] <= reg_wdata[31-k];
            end
        end

        assign ext_clr[k] = wr_epend & reg_wdata[31-k];

        irq_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq_n     (ext_irq_n[k]),
            .edge_mode (sense_q[k]),
            .clr       (ext_clr[k]),
            .pending   (ext_pend[k])
        );

        assign req[k]     = ext_pend[k] & emask_q[k];
        assign src_num[k] = ext_src_num(k);
    end

    // Per internal source: enable bit, level request and number.
    for (genvar i = 0; i < NUM_INT; i++) begin : g_int
        always_ff @(posedge clk) begin
            if (!rst_n)        imask_q[i] <= 1'b0;
            else if (wr_imask) imask_q[i] <= reg_wdata[31-i];
        end

        assign req[EXT_LINES+i]     = ~int_irq_n[i] & imask_q[i];
        assign src_num[EXT_LINES+i] = VEC_W'(INT_BASE + i);
    end

    irq_vector_sel #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_vsel (
        .req     (req),
        .src_num (src_num),
        .vec     (vec)
    );

    assign cpu_irq = (vec != '0);

    // Read multiplexer: place each field at its register bit positions.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_SENSE: for (int k = 0; k < EXT_LINES; k++) reg_rdata[15-k] = sense_q[k];
            A_EMASK: for (int k = 0; k < EXT_LINES; k++) reg_rdata[31-k] = emask_q[k];
            A_EPEND: for (int k = 0; k < EXT_LINES; k++) reg_rdata[31-k] = ext_pend[k];
            A_IMASK: for (int i = 0; i < NUM_INT; i++)   reg_rdata[31-i] = imask_q[i];
            A_VEC:   reg_rdata[VEC_W-1:0] = vec;
            default: reg_rdata = '0;
        endcase
    end

    // R1: reset leaves every enable and sense bit cleared.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (emask_q == '0 && imask_q == '0 && sense_q == '0));

    // R9: the request output tracks the presence of an enabled pending source.
    p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (|req));

    // R8: the vector only ever holds zero or a legal source number.
    p_vec_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec == '0) || (int'(vec) >= EXT_SRC_BASE + 1 && int'(vec) <= EXT_SRC_BASE + 7)
        || (int'(vec) == EXT0_SRC_NUM)
        || (int'(vec) >= INT_BASE && int'(vec) < INT_BASE + NUM_INT));
endmodule

// File: tb/extint_vec_ctl_tb.sv
module extint_vec_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ext_irq_n = 8'hFF;
    logic [7:0]  int_irq_n = 8'hFF;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        cpu_irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    extint_vec_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .int_irq_n(int_irq_n),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
    );

    // Table: {ext_n, int_n, ext enable, int enable, expected vector}, level mode.
    localparam logic [86:0] VECS [12] = '{
        {8'hFF, 8'hFF, 32'hFF000000, 32'hFF000000, 7'd0},
        {8'hFE, 8'hFF, 32'hFF000000, 32'hFF000000, 7'd48},
        {8'hF6, 8'hFF, 32'hFF000000, 32'hFF000000, 7'd19},
        {8'h7F, 8'hFF, 32'hFF000000, 32'hFF000000, 7'd23},
        {8'hFF, 8'hFE, 32'hFF000000, 32'hFF000000, 7'd64},
        {8'hFF, 8'h7F, 32'hFF000000, 32'hFF000000, 7'd71},
        {8'hFE, 8'hFE, 32'hFF000000, 32'hFF000000, 7'd48},
        {8'hF6, 8'hFF, 32'hEF000000, 32'hFF000000, 7'd48},
        {8'h00, 8'h00, 32'hFF000000, 32'hFF000000, 7'd17},
        {8'h00, 8'h00, 32'h00000000, 32'hFF000000, 7'd64},
        {8'h00, 8'h00, 32'h80000000, 32'h00000000, 7'd48},
        {8'h00, 8'h00, 32'h00000000, 32'h00000000, 7'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] exp_pend;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state of every register and the request output.
        for (int a = 0; a < 5; a++) begin
            bus_read(3'(a), rd);
            check("R1 reset read", rd, 32'd0);
        end
        check("R1 cpu_irq after reset", {31'd0, cpu_irq}, 32'd0);

        // Table walk: R3/R4/R8/R9/R10 in level mode.
        for (int v = 0; v < 12; v++) begin
            bus_write(3'd1, VECS[v][38:7]);
            bus_write(3'd3, VECS[v][38:7] & 32'h0 | VECS[v][38:7] ? VECS[v][38:7] : 32'h0);
            bus_write(3'd3, VECS[v][38:7]);
            bus_write(3'd1, VECS[v][70:39]);
            @(negedge clk);
            ext_irq_n = VECS[v][86:79];
            int_irq_n = VECS[v][78:71];
            wait_cyc(3);
            bus_read(3'd4, rd);
            check("R8 vector table", rd, {25'd0, VECS[v][6:0]});
            check("R9 cpu_irq table", {31'd0, cpu_irq}, {31'd0, (VECS[v][6:0] != 7'd0)});
            exp_pend = 32'd0;
            for (int k = 0; k < 8; k++) exp_pend[31-k] = ~VECS[v][79+k];
            bus_read(3'd2, rd);
            check("R3 pending map", rd, exp_pend);
        end

        ext_irq_n = 8'hFF; int_irq_n = 8'hFF;
        bus_write(3'd3, 32'd0);

        // R2: sense register bit positions.
        bus_write(3'd0, 32'hFFFFFFFF);
        bus_read(3'd0, rd);
        check("R2 sense writable bits", rd, 32'h0000FF00);
        bus_write(3'd0, 32'h00002000);
        bus_read(3'd0, rd);
        check("R2 pin2 edge bit13", rd, 32'h00002000);
        bus_write(3'd1, 32'h20000000);
        wait_cyc(4);

        // R5: a fall latches and survives the input returning high.
        ext_irq_n[2] = 1'b0;
        wait_cyc(4);
        bus_read(3'd2, rd);
        check("R5 edge latched", rd, 32'h20000000);
        bus_read(3'd4, rd);
        check("R8 pin2 vector", rd, 32'd18);
        ext_irq_n[2] = 1'b1;
        wait_cyc(4);
        bus_read(3'd2, rd);
        check("R5 held after rise", rd, 32'h20000000);

        // R6: write 0 keeps, write 1 clears.
        bus_write(3'd2, 32'hDFFFFFFF);
        bus_read(3'd2, rd);
        check("R6 write zero ignored", rd, 32'h20000000);
        bus_write(3'd2, 32'h20000000);
        bus_read(3'd2, rd);
        check("R6 write one clears", rd, 32'd0);
        check("R9 irq low after clear", {31'd0, cpu_irq}, 32'd0);

        // R5: held-low pin and rising edge set nothing.
        ext_irq_n[2] = 1'b0;
        wait_cyc(4);
        bus_write(3'd2, 32'h20000000);
        wait_cyc(4);
        bus_read(3'd2, rd);
        check("R5 held low no relatch", rd, 32'd0);
        ext_irq_n[2] = 1'b1;
        wait_cyc(4);
        bus_read(3'd2, rd);
        check("R5 rising edge ignored", rd, 32'd0);

        // R6: a new fall in the same cycle as a clear wins.
        ext_irq_n[2] = 1'b0;
        wait_cyc(4);
        ext_irq_n[2] = 1'b1;
        wait_cyc(4);
        @(negedge clk);
        ext_irq_n[2] = 1'b0;
        @(negedge clk);
        bus_write(3'd2, 32'h20000000);
        wait_cyc(2);
        bus_read(3'd2, rd);
        check("R6 set beats clear", rd, 32'h20000000);
        ext_irq_n[2] = 1'b1;
        wait_cyc(4);
        bus_write(3'd2, 32'h20000000);

        // R7: disabled source still pends, wins once enabled.
        bus_write(3'd1, 32'h0);
        ext_irq_n[2] = 1'b0;
        wait_cyc(4);
        bus_read(3'd2, rd);
        check("R7 masked still pending", rd, 32'h20000000);
        bus_read(3'd4, rd);
        check("R7 masked vector zero", rd, 32'd0);
        check("R7 masked irq low", {31'd0, cpu_irq}, 32'd0);
        bus_write(3'd1, 32'h20000000);
        bus_read(3'd4, rd);
        check("R7 unmasked vector", rd, 32'd18);
        ext_irq_n[2] = 1'b1;
        wait_cyc(4);
        bus_write(3'd2, 32'h20000000);

        // R4: level pin latency and clear ignored.
        bus_write(3'd1, 32'h04000000);
        reg_addr = 3'd4;
        @(negedge clk);
        ext_irq_n[5] = 1'b0;
        @(negedge clk);
        #1 check("R4 one edge not yet", reg_rdata, 32'd0);
        @(negedge clk);
        #1 check("R4 two edges pending", reg_rdata, 32'd21);
        bus_write(3'd2, 32'h04000000);
        bus_read(3'd4, rd);
        check("R4 level clear ignored", rd, 32'd21);
        ext_irq_n[5] = 1'b1;
        wait_cyc(3);
        bus_read(3'd4, rd);
        check("R4 released", rd, 32'd0);

        // R10: internal source reaches the vector without delay.
        bus_write(3'd3, 32'h10000000);
        reg_addr = 3'd4;
        @(negedge clk);
        int_irq_n[3] = 1'b0;
        #1 check("R10 internal immediate", reg_rdata, 32'd67);

        // R11: vector read-only, unused address reads zero.
        bus_write(3'd4, 32'h0000007F);
        bus_read(3'd4, rd);
        check("R11 vector write ignored", rd, 32'd67);
        bus_write(3'd7, 32'hFFFFFFFF);
        bus_read(3'd7, rd);
        check("R11 unused reads zero", rd, 32'd0);
        bus_read(3'd1, rd);
        check("R11 unused write no effect", rd, 32'h04000000);

        // R1: reset mid-run clears enables and sense bits.
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        bus_read(3'd0, rd);
        check("R1 sense after reset", rd, 32'd0);
        bus_read(3'd3, rd);
        check("R1 int enable after reset", rd, 32'd0);
        check("R1 irq after reset", {31'd0, cpu_irq}, 32'd0);

        finish_run();
    end
endmodule